// File: doc/BRIEF.md
# MDIO Management Command Engine

This block turns a single 32-bit command/status word into a complete clause-22 management frame on a two-wire MDC/MDIO bus to an external PHY. Software writes one word that carries a go flag, a read/write selector, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The engine then generates the management clock by dividing the system clock, and shifts the whole frame out MSB first. For reads, it releases the data line during turnaround and data, and collects the PHY's reply.

While a frame is in flight, bit 31 of the same register reads as 1. Software polls the register until bit 31 drops. After a read, the low half of the register holds the captured PHY value. Writes that arrive while a frame runs are discarded, so an in-flight frame can never be disturbed.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, `rd_data` is zero, `mdc` is low and `mdio_oe` is low.
- R2: A write with bit 31 set while idle starts a frame. `rd_data[31]` reads 1 from the next cycle and drops by itself after exactly 64*CLK_DIV clock cycles.
- R3: A write frame (bit 30 = 0) puts these bits on `mdio_o`, MSB first, each stable at the MDC rising edge: 32 ones, start 01, opcode 01, PHY address from bits 25:21, register address from bits 20:16, turnaround 10, then the data from bits 15:0.
- R4: A read frame (bit 30 = 1) uses opcode 10. `mdio_oe` is high for the first 46 bits and low for the last 18 bits (turnaround plus data).
- R5: During a read, `mdio_i` is sampled at the MDC rising edge of each of the 16 data bits, MSB first. Once bit 31 clears, `rd_data[15:0]` holds that value.
- R6: Any write while busy is ignored. `rd_data[30:0]` keeps the accepted command and the frame on the wire is unchanged.
- R7: While busy, each MDC high and low phase lasts CLK_DIV/2 clock cycles.
- R8: A write with bit 31 clear while idle only stores bits 30:0, which read back unchanged. No frame starts and `mdc` stays low.
- R9: `mdio_oe` is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Command word written to the register |
| rd_data | output | 32 | Register read value: bit 31 busy, bits 30:0 command/result |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the data pad (1 = drive) |
| mdio_i | input | 1 | Management data seen from the pad |

## Verification
The assertions take for granted that CLK_DIV is even and at least 2. They also take for granted that `wr_en` is a one-cycle strobe, so the field-hold check can treat every write during busy as stray. The stimulus changes `wr_en` and `wr_data` only on falling clock edges, and a deliberate write lands in the middle of a frame. The PHY model changes `mdio_i` only right after a falling MDC edge, so its value is settled long before the engine samples it on the next rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DRIVE_BITS = 46;   // preamble + start + op + addresses
  localparam int DATA_FIRST = 48;   // index of first data bit
  localparam int REQ_BIT    = 31;
  localparam int OP_BIT     = 30;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic       rd,
      input logic [4:0] phy,
      input logic [4:0] regad,
      input logic [15:0] data);
    logic [1:0] op;
    logic [1:0] ta;
    logic [15:0] payload;
    op      = rd ? 2'b10 : 2'b01;
    ta      = rd ? 2'b11 : 2'b10;
    payload = rd ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == CW'(HALF - 1));
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mdc);  // R7

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (mdc != $past(mdc))) |-> ($past(cnt) == CW'(HALF - 1)));  // R7
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  is_read_in,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rise_stb,
  input  logic                  fall_stb,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rx_data
);
  logic [FRAME_BITS-1:0] sr;
  logic [5:0]            idx;
  logic [5:0]            idx_nxt;
  logic                  rd_q;

  assign idx_nxt = idx + 6'd1;
  assign mdio_o  = sr[FRAME_BITS-1];
  assign done    = busy && fall_stb && (idx == 6'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sr      <= '1;
      idx     <= '0;
      mdio_oe <= 1'b0;
      rd_q    <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      sr      <= frame_in;
      idx     <= '0;
      mdio_oe <= 1'b1;
      rd_q    <= is_read_in;
    end else if (busy) begin
      if (rise_stb && rd_q && (idx >= 6'(DATA_FIRST)))
        rx_data <= {rx_data[14:0], mdio_i};
      if (fall_stb) begin
        if (done) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= idx_nxt;
          sr      <= {sr[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= !(rd_q && (idx_nxt >= 6'(DRIVE_BITS)));
        end
      end
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (idx >= 6'(DRIVE_BITS))) |-> !mdio_oe);  // R4

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);  // R9
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [30:0]           cmd_q;
  logic                  busy;
  logic                  start;
  logic                  rise_stb;
  logic                  fall_stb;
  logic                  done;
  logic [15:0]           rx_data;
  logic [FRAME_BITS-1:0] frame;

  assign start   = wr_en && wr_data[REQ_BIT] && !busy;
  assign frame   = build_frame(wr_data[OP_BIT], wr_data[25:21], wr_data[20:16], wr_data[15:0]);
  assign rd_data = {busy, cmd_q};

  always_ff @(posedge clk) begin
    if (rst)
      cmd_q <= '0;
    else if (wr_en && !busy)
      cmd_q <= wr_data[30:0];
    else if (done && cmd_q[OP_BIT])
      cmd_q[15:0] <= rx_data;
  end

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_shift u_shift (
    .clk(clk), .rst(rst), .start(start), .is_read_in(wr_data[OP_BIT]),
    .frame_in(frame), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rx_data(rx_data)
  );

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[REQ_BIT] && !busy) |=> busy);  // R2

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_q[30:16]));  // R6
endmodule

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
  localparam int DIV  = 20;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  mdio_cmd_engine #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct { logic [63:0] bits; logic [63:0] oe; } exp_t;
  exp_t exp_q[$];

  int errors = 0;
  int checks = 0;
  int frames_seen = 0;
  logic [15:0] cur_reply = '0;
  bit half_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: PHY side capture, reply drive, MDC phase timing
  logic [63:0] cap_b = '0, cap_oe = '0;
  int rc = 0, fc = 0, hc = 0;
  logic mdc_prev = 1'b0, busy_prev = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      rc = 0; fc = 0; hc = 0; mdc_prev = 1'b0; busy_prev = 1'b0;
    end else begin
      if (rd_data[31] && !busy_prev) hc = 0;
      else hc++;
      if (mdc != mdc_prev) begin
        if (rd_data[31] && hc != HALF) half_bad = 1;
        hc = 0;
      end
      if (mdc && !mdc_prev) begin
        cap_b  = {cap_b[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        rc++;
        if (rc == 64) begin
          rc = 0;
          frames_seen++;
          if (exp_q.size() == 0) begin
            chk(0, "R6", "unexpected frame", cap_b, 64'd0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(cap_oe == e.oe, "R4", "drive enable pattern", cap_oe, e.oe);
            chk(((cap_b ^ e.bits) & e.oe) == 64'd0, "R3", "frame bits", cap_b, e.bits);
          end
        end
      end
      if (!mdc && mdc_prev) begin
        fc++;
        if (fc >= 64) begin fc = 0; mdio_i <= 1'b1; end
        else if (fc >= 48) mdio_i <= cur_reply[63 - fc];
        else mdio_i <= 1'b1;
      end
      mdc_prev  = mdc;
      busy_prev = rd_data[31];
    end
  end

  function automatic exp_t make_exp(input logic [31:0] w);
    exp_t e;
    logic rd;
    rd = w[30];
    e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), w[25:21], w[20:16],
              2'b10, w[15:0]};
    e.oe = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    return e;
  endfunction

  task automatic reg_write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (rd_data[31] && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // driver: push expectation, launch, poll, check register afterwards
  task automatic run_cmd(input logic [31:0] w, input logic [15:0] reply);
    int n;
    logic [30:0] exp_reg;
    cur_reply = reply;
    half_bad = 0;
    exp_q.push_back(make_exp(w));
    reg_write(w);
    chk(rd_data[31] == 1'b1, "R2", "busy after start", {63'd0, rd_data[31]}, 64'd1);
    wait_idle(n);
    chk(n == 64 * DIV, "R2", "busy duration", 64'(n), 64'(64 * DIV));
    chk(half_bad == 0, "R7", "mdc half period", {63'd0, half_bad}, 64'd0);
    exp_reg = w[30] ? {w[30:16], reply} : w[30:0];
    chk(rd_data == {1'b0, exp_reg}, w[30] ? "R5" : "R3", "register after frame",
        64'(rd_data), 64'({1'b0, exp_reg}));
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 32'd0, "R1", "reset register", 64'(rd_data), 64'd0);
    chk(mdc == 1'b0, "R1", "reset mdc", {63'd0, mdc}, 64'd0);
    chk(mdio_oe == 1'b0, "R9", "reset drive enable", {63'd0, mdio_oe}, 64'd0);

    // write frames
    run_cmd({1'b1, 1'b0, 4'b0, 5'h03, 5'h04, 16'hA55A}, 16'h0000);
    run_cmd({1'b1, 1'b0, 4'b0, 5'h1F, 5'h1F, 16'hFFFF}, 16'h0000);
    // read frames
    run_cmd({1'b1, 1'b1, 4'b0, 5'h1F, 5'h00, 16'h0000}, 16'h1234);
    run_cmd({1'b1, 1'b1, 4'b0, 5'h00, 5'h1F, 16'h0000}, 16'h8001);
    chk(mdio_oe == 1'b0, "R9", "idle drive enable", {63'd0, mdio_oe}, 64'd0);

    // R6: write while busy is discarded
    begin
      logic [31:0] w;
      w = {1'b1, 1'b0, 4'b0, 5'h02, 5'h07, 16'h0F0F};
      exp_q.push_back(make_exp(w));
      half_bad = 0;
      reg_write(w);
      repeat (300) @(negedge clk);
      reg_write(32'hC3FF_FFFF);
      chk(rd_data == {1'b1, w[30:0]}, "R6", "register mid-frame", 64'(rd_data),
          64'({1'b1, w[30:0]}));
      wait_idle(n);
      chk(rd_data == {1'b0, w[30:0]}, "R6", "register after frame", 64'(rd_data),
          64'({1'b0, w[30:0]}));
      repeat (5) @(negedge clk);
    end

    // R8: store without start
    reg_write(32'h4123_4567);
    repeat (100) @(negedge clk);
    chk(rd_data == 32'h4123_4567, "R8", "stored word", 64'(rd_data), 64'h4123_4567);
    chk(mdc == 1'b0, "R8", "mdc idle", {63'd0, mdc}, 64'd0);
    chk(mdio_oe == 1'b0, "R9", "no drive after store", {63'd0, mdio_oe}, 64'd0);

    // a read after a stored word still works
    run_cmd({1'b1, 1'b1, 4'b0, 5'h15, 5'h0A, 16'h0000}, 16'h5AA5);

    chk(exp_q.size() == 0, "R3", "frames outstanding", 64'(exp_q.size()), 64'd0);
    chk(frames_seen == 6, "R6", "frames on wire", 64'(frames_seen), 64'd6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: cycles=%0d expected<%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule